// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block turns a single multi-register transfer command into a stream of per-register memory requests. A command carries a 16-bit register-select mask, a base address, an addressing mode (increment or decrement, with the step taken before or after each access), a load/store direction and a writeback flag. For every selected register the sequencer offers one request holding a byte address, the register index and the direction, and it advances by one request per accepted valid/ready handshake toward memory.

The lowest-numbered register always receives the lowest address in every mode. In the decrement modes the first address is therefore derived up front from the mask population count, and the sequence then climbs in 4-byte steps. When the last request has been accepted, a one-cycle completion pulse reports the updated base (base plus or minus four times the number of selected registers) so the register file can write it back. A full-descending stack falls out directly: a push is a decrement-before store with writeback, and a pop is an increment-after load with writeback, both on the stack pointer.

Top module: `blkxfer_seq`

## Requirements
- R1: `mode_i` is decoded as bit 1 = increment (1) or decrement (0) and bit 0 = step before (1) or after (0) the access; with n selected registers the first request address is base (inc/after, 2'b10), base+4 (inc/before, 2'b11), base-4n+4 (dec/after, 2'b00) or base-4n (dec/before, 2'b01).
- R2: Requests are issued for the set bits of the mask in ascending index order, and each accepted request is followed by one whose address is 4 higher, so the k-th request (from 0) carries address first+4k.
- R3: While `req_valid_o` is high and `req_ready_i` is low, the request (address, index, direction) is held unchanged.
- R4: `done_o` is a single-cycle pulse in the cycle right after the handshake of the last request, and `req_valid_o` is low in that cycle.
- R5: In the completion cycle `wb_value_o` equals base+4n for increment modes and base-4n for decrement modes; `wb_valid_o` is high in that cycle only when the writeback flag was set with the command.
- R6: An all-zero mask issues no requests, pulses `done_o` in the cycle after the command, and reports the unchanged base.
- R7: A `start_i` pulse while a transfer is in progress (`busy_o` high) is ignored and does not disturb the running sequence.
- R8: A command presented in the completion cycle is accepted, so its first request is offered in the next cycle; a dec/before store followed this way by an inc/after load on the same mask returns the base to its starting value.
- R9: Every request carries the command's direction bit on `req_load_o` (1 = load, 0 = store), constant for the whole transfer.
- R10: After reset `busy_o`, `req_valid_o`, `done_o` and `wb_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Command strobe, taken when not busy |
| mode_i | input | 2 | Addressing mode (bit 1 increment, bit 0 step-before) |
| load_i | input | 1 | Direction: 1 load, 0 store |
| wb_en_i | input | 1 | Request base writeback at completion |
| mask_i | input | 16 | Register-select mask |
| base_i | input | 32 | Base address |
| busy_o | output | 1 | Transfer in progress |
| req_valid_o | output | 1 | Memory request valid |
| req_ready_i | input | 1 | Memory accepts the request |
| req_addr_o | output | 32 | Request byte address |
| req_idx_o | output | 4 | Register index of the request |
| req_load_o | output | 1 | Request direction |
| done_o | output | 1 | Completion pulse |
| wb_valid_o | output | 1 | Writeback of the base requested |
| wb_value_o | output | 32 | Updated base value |

## Verification
The completion pulse of one transfer and the acceptance of the next command can fall in the same cycle, since the sequencer is idle during the completion cycle. The bench provokes this by issuing a pop command in the exact cycle a push reports completion, using the reported base as the new base, then judges that the pop's first request appears one cycle later at the push's lowest address and that the final reported base equals the original pointer. Requests are also checked against arithmetic expectations under pseudo-random ready stalls and with stray command strobes during busy cycles.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;
  typedef enum logic [1:0] {
    MODE_DEC_AFTER  = 2'b00,
    MODE_DEC_BEFORE = 2'b01,
    MODE_INC_AFTER  = 2'b10,
    MODE_INC_BEFORE = 2'b11
  } xfer_mode_e;
endpackage

// File: rtl/blkxfer_popcnt.sv
module blkxfer_popcnt #(
  parameter int W  = 16,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < W; i++) begin
      cnt_o = cnt_o + CW'(vec_i[i]);
    end
  end
endmodule

// File: rtl/blkxfer_lowpick.sv
module blkxfer_lowpick #(
  parameter int W  = 16,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic [W-1:0]  onehot_o
);
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end

  assign onehot_o = vec_i & (~vec_i + W'(1));
endmodule

// File: rtl/blkxfer_addrgen.sv
module blkxfer_addrgen
  import blkxfer_pkg::*;
#(
  parameter int AW   = 32,
  parameter int CW   = 5,
  parameter int STEP = 4
) (
  input  logic [AW-1:0] base_i,
  input  xfer_mode_e    mode_i,
  input  logic [CW-1:0] cnt_i,
  output logic [AW-1:0] first_o,
  output logic [AW-1:0] final_o
);
  logic [AW-1:0] span;
  logic [AW-1:0] step_v;

  assign step_v = AW'(STEP);
  assign span   = AW'(cnt_i) * step_v;

  always_comb begin
    unique case (mode_i)
      MODE_INC_AFTER:  first_o = base_i;
      MODE_INC_BEFORE: first_o = base_i + step_v;
      MODE_DEC_AFTER:  first_o = base_i - span + step_v;
      default:         first_o = base_i - span;
    endcase
    final_o = mode_i[1] ? (base_i + span) : (base_i - span);
  end
endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
  import blkxfer_pkg::*;
#(
  parameter int AW   = 32,
  parameter int NREG = 16,
  parameter int STEP = 4,
  localparam int IW  = $clog2(NREG),
  localparam int CW  = $clog2(NREG + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [1:0]      mode_i,
  input  logic            load_i,
  input  logic            wb_en_i,
  input  logic [NREG-1:0] mask_i,
  input  logic [AW-1:0]   base_i,
  output logic            busy_o,
  output logic            req_valid_o,
  input  logic            req_ready_i,
  output logic [AW-1:0]   req_addr_o,
  output logic [IW-1:0]   req_idx_o,
  output logic            req_load_o,
  output logic            done_o,
  output logic            wb_valid_o,
  output logic [AW-1:0]   wb_value_o
);
  // state
  logic            busy_q, busy_d;
  logic            done_q, done_d;
  logic            wbf_q, wbf_d;
  logic            load_q, load_d;
  logic [NREG-1:0] rem_q, rem_d;
  logic [AW-1:0]   addr_q, addr_d;
  logic [AW-1:0]   fin_q, fin_d;

  // enables
  logic            cmd_en;
  logic            adv_en;

  // helpers
  logic [CW-1:0]   sel_cnt;
  logic [AW-1:0]   first_addr;
  logic [AW-1:0]   final_base;
  logic [IW-1:0]   cur_idx;
  logic [NREG-1:0] cur_hot;
  logic [NREG-1:0] rem_after;

  blkxfer_popcnt #(.W(NREG), .CW(CW)) u_popcnt (
    .vec_i (mask_i),
    .cnt_o (sel_cnt)
  );

  blkxfer_addrgen #(.AW(AW), .CW(CW), .STEP(STEP)) u_addrgen (
    .base_i  (base_i),
    .mode_i  (xfer_mode_e'(mode_i)),
    .cnt_i   (sel_cnt),
    .first_o (first_addr),
    .final_o (final_base)
  );

  blkxfer_lowpick #(.W(NREG), .IW(IW)) u_lowpick (
    .vec_i    (rem_q),
    .idx_o    (cur_idx),
    .onehot_o (cur_hot)
  );

  assign cmd_en    = start_i & ~busy_q;
  assign adv_en    = busy_q & req_ready_i;
  assign rem_after = rem_q & ~cur_hot;

  // next state
  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    wbf_d  = wbf_q;
    load_d = load_q;
    rem_d  = rem_q;
    addr_d = addr_q;
    fin_d  = fin_q;
    if (cmd_en) begin
      busy_d = |mask_i;
      done_d = ~(|mask_i);
      wbf_d  = wb_en_i;
      load_d = load_i;
      rem_d  = mask_i;
      addr_d = first_addr;
      fin_d  = final_base;
    end else if (adv_en) begin
      rem_d  = rem_after;
      addr_d = addr_q + AW'(STEP);
      if (rem_after == '0) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      wbf_q  <= 1'b0;
      load_q <= 1'b0;
      rem_q  <= '0;
      addr_q <= '0;
      fin_q  <= '0;
    end else begin
      done_q <= done_d;
      if (cmd_en | adv_en) begin
        busy_q <= busy_d;
        rem_q  <= rem_d;
        addr_q <= addr_d;
      end
      if (cmd_en) begin
        wbf_q  <= wbf_d;
        load_q <= load_d;
        fin_q  <= fin_d;
      end
    end
  end

  assign busy_o      = busy_q;
  assign req_valid_o = busy_q;
  assign req_addr_o  = addr_q;
  assign req_idx_o   = cur_idx;
  assign req_load_o  = load_q;
  assign done_o      = done_q;
  assign wb_valid_o  = done_q & wbf_q;
  assign wb_value_o  = fin_q;
endmodule

// File: rtl/blkxfer_seq_chk.sv
module blkxfer_seq_chk #(
  parameter int AW   = 32,
  parameter int IW   = 4,
  parameter int STEP = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid_o,
  input logic          req_ready_i,
  input logic [AW-1:0] req_addr_o,
  input logic [IW-1:0] req_idx_o,
  input logic          req_load_o,
  input logic          done_o,
  input logic          wb_valid_o
);
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_addr_o)
                                       && $stable(req_idx_o) && $stable(req_load_o)));

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && req_ready_i) |=> (!req_valid_o ||
      (req_addr_o == $past(req_addr_o) + AW'(STEP) && req_idx_o > $past(req_idx_o))));

  assert_done_novalid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !req_valid_o);

  assert_fall_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_valid_o) |-> done_o);

  assert_wb_in_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid_o |-> done_o);

  assert_dir_const_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && $past(req_valid_o)) |-> $stable(req_load_o));
endmodule

bind blkxfer_seq blkxfer_seq_chk #(.AW(AW), .IW(IW), .STEP(STEP)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid_o (req_valid_o),
  .req_ready_i (req_ready_i),
  .req_addr_o  (req_addr_o),
  .req_idx_o   (req_idx_o),
  .req_load_o  (req_load_o),
  .done_o      (done_o),
  .wb_valid_o  (wb_valid_o)
);

// File: tb/blkxfer_seq_tb_top.sv
module blkxfer_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  mode_i = '0;
  logic        load_i = 1'b0;
  logic        wb_en_i = 1'b0;
  logic [15:0] mask_i = '0;
  logic [31:0] base_i = '0;
  logic        req_ready_i = 1'b0;
  logic        busy_o, req_valid_o, req_load_o, done_o, wb_valid_o;
  logic [31:0] req_addr_o, wb_value_o;
  logic [3:0]  req_idx_o;

  int   n_chk = 0;
  int   n_err = 0;
  bit   all_done = 1'b0;
  bit   rdy_always = 1'b1;
  logic [7:0] lfsr = 8'hA5;

  always #5 clk = ~clk;

  blkxfer_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .load_i(load_i), .wb_en_i(wb_en_i), .mask_i(mask_i), .base_i(base_i),
    .busy_o(busy_o), .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
    .req_addr_o(req_addr_o), .req_idx_o(req_idx_o), .req_load_o(req_load_o),
    .done_o(done_o), .wb_valid_o(wb_valid_o), .wb_value_o(wb_value_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int popc(input logic [15:0] m);
    int c = 0;
    for (int i = 0; i < 16; i++) c += int'(m[i]);
    return c;
  endfunction

  function automatic logic [31:0] exp_first(input logic [1:0] md, input logic [31:0] b,
                                            input int n);
    case (md)
      2'b10:   return b;
      2'b11:   return b + 32'd4;
      2'b00:   return b - 32'(4 * n) + 32'd4;
      default: return b - 32'(4 * n);
    endcase
  endfunction

  function automatic logic [31:0] exp_final(input logic [1:0] md, input logic [31:0] b,
                                            input int n);
    return md[1] ? b + 32'(4 * n) : b - 32'(4 * n);
  endfunction

  // caller is at a negedge; returns at the following negedge
  task automatic launch(input logic [1:0] md, input logic [15:0] msk, input logic [31:0] bs,
                        input bit wb, input bit ld);
    start_i = 1'b1; mode_i = md; mask_i = msk; base_i = bs; wb_en_i = wb; load_i = ld;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // follows one transfer; returns at the negedge where done_o is seen
  task automatic track(input logic [1:0] md, input logic [15:0] msk, input logic [31:0] bs,
                       input bit wb, input bit ld, input bit poke);
    int n = popc(msk);
    logic [31:0] first = exp_first(md, bs, n);
    logic [15:0] remm = msk;
    int k = 0;
    bit prev_last = 1'b0;
    int exp_idx;
    for (int cyc = 0; cyc < 400; cyc++) begin
      start_i = 1'b0;
      req_ready_i = rdy_always | lfsr[0];
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      #1;
      if (done_o) begin
        chk(k == n, "R2 request count", 32'(k), 32'(n));
        chk(prev_last || (n == 0 && cyc == 0), "R4/R6 done timing", 32'(cyc), 32'(k));
        chk(!req_valid_o, "R4 valid low in done cycle", 32'(req_valid_o), 32'd0);
        chk(wb_valid_o == wb, "R5 writeback flag", 32'(wb_valid_o), 32'(wb));
        chk(wb_value_o == exp_final(md, bs, n), "R5/R6 final base", wb_value_o,
            exp_final(md, bs, n));
        return;
      end
      chk(!prev_last, "R4 done missing after last request", 32'(done_o), 32'd1);
      chk(req_valid_o, "R2 request expected while busy", 32'(req_valid_o), 32'd1);
      exp_idx = 0;
      for (int i = 15; i >= 0; i--) if (remm[i]) exp_idx = i;
      chk(32'(req_idx_o) == 32'(exp_idx), "R2 register index", 32'(req_idx_o),
          32'(exp_idx));
      chk(req_addr_o == first + 32'(4 * k), "R1/R2 request address", req_addr_o,
          first + 32'(4 * k));
      chk(req_load_o == ld, "R9 direction", 32'(req_load_o), 32'(ld));
      if (req_ready_i) begin
        remm[exp_idx] = 1'b0;
        k++;
        prev_last = (remm == '0);
      end else begin
        prev_last = 1'b0;
      end
      if (poke && cyc == 0) begin
        // R7: stray command while busy
        start_i = 1'b1; mode_i = ~md; mask_i = 16'hAAAA; base_i = 32'h5555_0000;
        load_i = ~ld; wb_en_i = ~wb;
      end
      @(negedge clk);
    end
    chk(1'b0, "R4 transfer never completed", 32'(k), 32'(n));
  endtask

  initial begin
    #(100000 * 10);
    if (!all_done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [15:0] msk;
    logic [31:0] sp;
    repeat (3) @(negedge clk);
    chk(!busy_o && !req_valid_o, "R10 reset idle", {busy_o, req_valid_o}, 32'd0);
    chk(!done_o && !wb_valid_o, "R10 reset no done", {done_o, wb_valid_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // sweep modes, masks and ready patterns
    for (int rm = 0; rm < 2; rm++) begin
      rdy_always = (rm == 0);
      for (int md = 0; md < 4; md++) begin
        for (int j = 0; j < 40; j++) begin
          case (j)
            0:       msk = 16'h0000;   // R6
            1:       msk = 16'h0001;
            2:       msk = 16'h8000;
            3:       msk = 16'hFFFF;
            default: msk = 16'(j * 32'h2F1B) ^ 16'(j << 9);
          endcase
          launch(2'(md), msk, 32'h0001_0000 + 32'(j * 64), j[0], j[1]);
          track(2'(md), msk, 32'h0001_0000 + 32'(j * 64), j[0], j[1],
                (j % 5 == 2) && (msk != 0));
          @(negedge clk);
          chk(!done_o && !busy_o, "R4 single-cycle done", {busy_o, done_o}, 32'd0);
        end
      end
    end

    // R8: push then pop issued in the completion cycle
    rdy_always = 1'b0;
    for (int j = 0; j < 12; j++) begin
      msk = (j == 0) ? 16'h4070 : 16'(j * 32'h3A57) | 16'h0001;
      launch(2'b01, msk, 32'h0000_2000, 1'b1, 1'b0);
      track(2'b01, msk, 32'h0000_2000, 1'b1, 1'b0, 1'b0);
      sp = wb_value_o;
      launch(2'b10, msk, sp, 1'b1, 1'b1);
      chk(req_valid_o, "R8 back-to-back command accepted", 32'(req_valid_o), 32'd1);
      track(2'b10, msk, sp, 1'b1, 1'b1, 1'b0);
      chk(wb_value_o == 32'h0000_2000, "R8 pointer restored", wb_value_o, 32'h0000_2000);
      @(negedge clk);
    end

    all_done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule